// File: doc/BRIEF.md
# Triggered One-Shot ADC Conversion Sequencer

This block is the control logic that sits between register writes, an external trigger line and an abstract analog conversion engine. Software turns the converter on with an enable bit and then sets an arm bit. Setting the arm bit does not begin a conversion. It only tells the block to wait for a trigger. Each rising edge of the trigger line then starts exactly one conversion on the channel currently held in the channel field. When the engine reports completion, the block stores the sample in a result register, pulses an end-of-conversion interrupt and goes back to waiting for the next trigger. The arm bit stays set throughout.

While a conversion runs, three kinds of event throw away the partial conversion and start it again at once: a new trigger edge, any write to the channel field, and a write that sets the arm bit again. Each restart uses the newest channel. Clearing the arm bit during a conversion stops it without a restart, and the converter stays enabled. Clearing the enable bit returns the block to its stopped state. The trigger line passes through a synchronizer and an edge detector, so the trigger may be asynchronous to the clock.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `conv_start_o`, `conv_abort_o`, `eoc_irq_o` and `result_o` are 0 and the block is stopped.
- R2: A control write stores enable = `ctl_en_i` and arm = `ctl_en_i & ctl_arm_i`, so a write with enable 0 stops the block and leaves it disarmed; a write with enable 1 and arm 0 enables it without starting anything.
- R3: Arming does not start a conversion. When armed, a rising trigger edge gives exactly one `conv_start_o` pulse, however long the trigger is held; the pulse appears in the cycle after the third rising clock edge that samples the trigger high.
- R4: `conv_ch_o` shows the channel field as it is after the write that cycle, at every start pulse, and it holds its value while that conversion runs.
- R5: `conv_done_i` sampled high while a conversion runs loads `result_o` with `conv_data_i` and raises `eoc_irq_o` for one cycle, both in the cycle after that edge. The block then stays armed and starts again on the next trigger edge.
- R6: A trigger edge during a conversion gives `conv_abort_o` and `conv_start_o` together for one cycle, and no interrupt is raised for the discarded conversion.
- R7: Any channel write during a conversion, including one that writes the same value, aborts the conversion and restarts it on the written channel.
- R8: A control write with enable 1 and arm 1 during a conversion aborts the conversion and restarts it.
- R9: A control write that clears the arm bit during a conversion gives `conv_abort_o` with no start pulse. The block stays enabled, so a later arm write and trigger start a conversion.
- R10: Trigger edges are ignored while stopped or while enabled but not armed.
- R11: A register write and a trigger edge in the same cycle give one start pulse, not two, using the newest channel.
- R12: `conv_done_i` is ignored outside a conversion and in any cycle where a restart or abort happens; in those cases there is no interrupt and `result_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_en_i | input | 1 | Enable bit value written |
| ctl_arm_i | input | 1 | Arm bit value written |
| chan_wr_i | input | 1 | Channel field write strobe |
| chan_i | input | CH_W | Channel value written |
| trig_i | input | 1 | Hardware trigger, asynchronous |
| conv_start_o | output | 1 | One-cycle start pulse to the engine |
| conv_abort_o | output | 1 | One-cycle abort pulse to the engine |
| conv_ch_o | output | CH_W | Channel the engine converts |
| conv_done_i | input | 1 | Engine completion strobe |
| conv_data_i | input | DATA_W | Engine sample data |
| result_o | output | DATA_W | Result register |
| eoc_irq_o | output | 1 | End-of-conversion interrupt pulse |

## Verification
The bench targets collisions. One case puts a trigger edge in the same cycle as a channel write during a conversion; a design that handled the two events one after the other would show two start pulses. Another case writes the channel with its current value; a design that compared values instead of reacting to the write would miss that restart. Other cases clear the arm bit during a conversion, which must abort without restarting or disabling the converter, and send completion strobes outside a conversion, which a careless design would turn into interrupts. Random writes, trigger toggles and stray strobes, compared cycle by cycle against a reference model, also catch a completion strobe that collides with a restart.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_STBY = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic edge_o
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], trig_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R3
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] result_o
);
    logic [DATA_W-1:0] res_d, res_q;

    always_comb begin
        res_d = cap_i ? data_i : res_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result_o = res_q;

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(res_q)); // R12
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr_i,
    input  logic            ctl_en_i,
    input  logic            ctl_arm_i,
    input  logic            chan_wr_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            trig_edge_i,
    input  logic            conv_done_i,
    output logic            conv_start_o,
    output logic            conv_abort_o,
    output logic [CH_W-1:0] conv_ch_o,
    output logic            eoc_o,
    output logic            cap_o
);
    typedef struct packed {
        seq_state_e      st;
        logic            en;
        logic            arm;
        logic [CH_W-1:0] chan;
        logic [CH_W-1:0] conv_ch;
        logic            start;
        logic            abort;
        logic            eoc;
    } fsm_t;

    fsm_t d, q;
    logic            en_n, arm_n, in_conv, rewrite, go;
    logic [CH_W-1:0] ch_n;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.abort = 1'b0;
        d.eoc   = 1'b0;
        cap_o   = 1'b0;
        en_n    = ctl_wr_i ? ctl_en_i : q.en;
        arm_n   = ctl_wr_i ? (ctl_en_i & ctl_arm_i) : q.arm;
        ch_n    = chan_wr_i ? chan_i : q.chan;
        in_conv = (q.st == ST_CONV);
        // register writes win over the trigger: both fold into one restart
        rewrite = in_conv & (chan_wr_i | (ctl_wr_i & arm_n));
        go      = arm_n & (rewrite | trig_edge_i);
        d.en    = en_n;
        d.arm   = arm_n;
        d.chan  = ch_n;
        d.abort = in_conv & (go | ~arm_n);
        if (!en_n) begin
            d.st = ST_STOP;
        end else if (go) begin
            d.st      = ST_CONV;
            d.start   = 1'b1;
            d.conv_ch = ch_n;
        end else if (in_conv && !arm_n) begin
            d.st = ST_STBY;
        end else if (in_conv && conv_done_i) begin
            d.st  = ST_STBY;
            d.eoc = 1'b1;
            cap_o = 1'b1;
        end else if (!in_conv) begin
            d.st = ST_STBY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_STOP, en: 1'b0, arm: 1'b0, chan: '0, conv_ch: '0,
                   start: 1'b0, abort: 1'b0, eoc: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign conv_start_o = q.start;
    assign conv_abort_o = q.abort;
    assign conv_ch_o    = q.conv_ch;
    assign eoc_o        = q.eoc;

    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.eoc |=> !q.eoc); // R5
    AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CONV && !q.start) |-> $stable(q.conv_ch)); // R4
    AST_ABORT_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        q.abort |-> $past(q.st) == ST_CONV); // R6
    AST_RESTART_NO_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> !q.eoc); // R12
    AST_STOP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_STOP && !$past(ctl_wr_i)) |-> !q.start); // R10
    AST_DISARM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_CONV && $past(ctl_wr_i) && !$past(ctl_arm_i))
        |-> (q.abort && !q.start)); // R9
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
    parameter int NUM_CH      = 8,
    parameter int DATA_W      = 10,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              ctl_en_i,
    input  logic              ctl_arm_i,
    input  logic              chan_wr_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              trig_i,
    output logic              conv_start_o,
    output logic              conv_abort_o,
    output logic [CH_W-1:0]   conv_ch_o,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              eoc_irq_o
);
    logic trig_edge;
    logic cap;

    adc_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .edge_o (trig_edge)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_i     (ctl_wr_i),
        .ctl_en_i     (ctl_en_i),
        .ctl_arm_i    (ctl_arm_i),
        .chan_wr_i    (chan_wr_i),
        .chan_i       (chan_i),
        .trig_edge_i  (trig_edge),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .conv_abort_o (conv_abort_o),
        .conv_ch_o    (conv_ch_o),
        .eoc_o        (eoc_irq_o),
        .cap_o        (cap)
    );

    adc_result_hold #(.DATA_W(DATA_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .data_i   (conv_data_i),
        .result_o (result_o)
    );
endmodule

// File: tb/tb_adc_trig_seq.sv
module tb_adc_trig_seq;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int CW  = 3;
    localparam int CONV_CYC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_en = 1'b0, ctl_arm = 1'b0;
    logic chan_wr = 1'b0;
    logic [CW-1:0] chan = '0;
    logic trig = 1'b0;
    logic stray = 1'b0;
    logic conv_start, conv_abort, eoc;
    logic [CW-1:0] conv_ch;
    logic [DW-1:0] result;
    logic conv_done;
    logic [DW-1:0] conv_data;

    // engine model
    logic eng_busy = 1'b0, eng_done = 1'b0;
    logic [3:0] eng_cnt = '0;
    logic [CW-1:0] eng_ch = '0;
    logic [DW-1:0] eng_data = '0;
    logic [DW-1:0] ana [NCH];

    // reference model
    logic [2:0] mp;
    logic m_en, m_arm, m_conv, m_start, m_abort, m_eoc;
    logic [CW-1:0] m_chan, m_ch;
    logic [DW-1:0] m_res;
    logic e, en_n, arm_n, rw, go;
    logic [CW-1:0] ch_n;

    int checks = 0, fails = 0;
    int n_st = 0, n_ab = 0, n_eoc = 0;
    logic [CW-1:0] last_ch = '0;
    int s0, a0, e0;

    always #5 clk = ~clk;

    assign conv_done = eng_done | stray;
    assign conv_data = eng_data;

    adc_trig_seq dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en), .ctl_arm_i(ctl_arm),
        .chan_wr_i(chan_wr), .chan_i(chan), .trig_i(trig),
        .conv_start_o(conv_start), .conv_abort_o(conv_abort), .conv_ch_o(conv_ch),
        .conv_done_i(conv_done), .conv_data_i(conv_data),
        .result_o(result), .eoc_irq_o(eoc)
    );

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n) begin
            eng_busy <= 1'b0;
        end else if (conv_start || conv_abort) begin
            eng_busy <= conv_start;
            eng_cnt  <= 4'(CONV_CYC);
            eng_ch   <= conv_ch;
        end else if (eng_busy) begin
            if (eng_cnt == 4'd1) begin
                eng_done <= 1'b1;
                eng_data <= ana[eng_ch];
                eng_busy <= 1'b0;
            end
            eng_cnt <= eng_cnt - 4'd1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mp = '0; m_en = 0; m_arm = 0; m_conv = 0; m_chan = '0; m_ch = '0;
            m_res = '0; m_start = 0; m_abort = 0; m_eoc = 0;
        end else begin
            e = mp[1] & ~mp[2];
            mp = {mp[1:0], trig};
            en_n  = ctl_wr ? ctl_en : m_en;
            arm_n = ctl_wr ? (ctl_en & ctl_arm) : m_arm;
            ch_n  = chan_wr ? chan : m_chan;
            rw = m_conv & (chan_wr | (ctl_wr & arm_n));
            go = arm_n & (rw | e);
            m_start = go;
            m_abort = m_conv & (go | ~arm_n);
            m_eoc = m_conv & arm_n & ~go & conv_done;
            if (m_eoc) m_res = conv_data;
            if (go) m_ch = ch_n;
            m_conv = go | (m_conv & arm_n & ~conv_done);
            m_en = en_n; m_arm = arm_n; m_chan = ch_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(conv_start == m_start, "R3", "start pulse", int'(conv_start), int'(m_start));
        chk(conv_abort == m_abort, "R6", "abort pulse", int'(conv_abort), int'(m_abort));
        chk(eoc == m_eoc, "R5", "eoc pulse", int'(eoc), int'(m_eoc));
        chk(result == m_res, "R12", "result reg", int'(result), int'(m_res));
        if (m_start) chk(conv_ch == m_ch, "R4", "start channel", int'(conv_ch), int'(m_ch));
        if (conv_start) begin n_st++; last_ch = conv_ch; end
        if (conv_abort) n_ab++;
        if (eoc) n_eoc++;
        ctl_wr = 0; chan_wr = 0; stray = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_ctl(input logic en, input logic arm);
        ctl_en = en; ctl_arm = arm; ctl_wr = 1; step();
    endtask

    task automatic wr_ch(input logic [CW-1:0] c);
        chan = c; chan_wr = 1; step();
    endtask

    task automatic pulse_trig();
        trig = 1; step(); step(); trig = 0;
    endtask

    task automatic mark();
        s0 = n_st; a0 = n_ab; e0 = n_eoc;
    endtask

    initial begin
        #1_500_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NCH; i++) ana[i] = DW'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(conv_start == 0 && conv_abort == 0 && eoc == 0, "R1", "pulses after reset",
            int'({conv_start, conv_abort, eoc}), 0);
        chk(result == 0, "R1", "result after reset", int'(result), 0);

        mark(); pulse_trig(); idle(6);
        chk(n_st == s0, "R10", "trigger while stopped", n_st - s0, 0);

        wr_ctl(1, 0); mark(); pulse_trig(); idle(6);
        chk(n_st == s0, "R10", "trigger while disarmed", n_st - s0, 0);

        wr_ch(3); wr_ctl(1, 1); mark(); idle(5);
        chk(n_st == s0, "R3", "arm alone starts nothing", n_st - s0, 0);
        trig = 1; step(); step(); step();
        chk(n_st == s0 + 1, "R3", "start on third edge", n_st - s0, 1);
        idle(4); trig = 0;
        chk(n_st == s0 + 1, "R3", "held trigger starts once", n_st - s0, 1);
        chk(last_ch == 3, "R4", "channel at start", int'(last_ch), 3);
        idle(8);
        chk(n_eoc == e0 + 1, "R5", "one interrupt", n_eoc - e0, 1);
        chk(result == ana[3], "R5", "result value", int'(result), int'(ana[3]));

        mark(); pulse_trig(); idle(12);
        chk(n_st == s0 + 1 && n_eoc == e0 + 1, "R5", "rearmed after completion",
            n_eoc - e0, 1);

        mark(); pulse_trig(); idle(4); pulse_trig(); idle(12);
        chk(n_st == s0 + 2, "R6", "trigger restart starts", n_st - s0, 2);
        chk(n_ab == a0 + 1, "R6", "trigger restart aborts", n_ab - a0, 1);
        chk(n_eoc == e0 + 1, "R6", "no irq for discarded", n_eoc - e0, 1);

        mark(); pulse_trig(); idle(4); wr_ch(3); idle(2);
        chk(n_ab == a0 + 1 && n_st == s0 + 2, "R7", "same-value channel write",
            n_ab - a0, 1);
        wr_ch(5); idle(12);
        chk(last_ch == 5, "R7", "restart on new channel", int'(last_ch), 5);
        chk(n_eoc == e0 + 1 && result == ana[5], "R7", "result of new channel",
            int'(result), int'(ana[5]));

        mark(); pulse_trig(); idle(4); wr_ctl(1, 1); idle(12);
        chk(n_st == s0 + 2 && n_ab == a0 + 1, "R8", "arm rewrite restarts",
            n_st - s0, 2);

        mark(); pulse_trig(); idle(4); wr_ctl(1, 0); idle(12);
        chk(n_ab == a0 + 1 && n_st == s0 + 1, "R9", "disarm aborts only", n_st - s0, 1);
        chk(n_eoc == e0, "R9", "no irq after disarm", n_eoc - e0, 0);
        mark(); wr_ctl(1, 1); pulse_trig(); idle(12);
        chk(n_st == s0 + 1 && n_eoc == e0 + 1, "R9", "still enabled", n_eoc - e0, 1);

        mark(); pulse_trig(); idle(4);
        trig = 1; step(); step(); wr_ch(6); trig = 0; idle(12);
        chk(n_st == s0 + 2, "R11", "merged restart", n_st - s0, 2);
        chk(last_ch == 6, "R11", "newest channel", int'(last_ch), 6);

        mark(); stray = 1; step(); idle(3);
        chk(n_eoc == e0, "R12", "stray done ignored", n_eoc - e0, 0);

        wr_ctl(0, 1); mark(); pulse_trig(); idle(6);
        chk(n_st == s0, "R2", "disable disarms", n_st - s0, 0);
        wr_ctl(1, 0); mark(); pulse_trig(); idle(6);
        chk(n_st == s0, "R2", "enable without arm", n_st - s0, 0);

        wr_ctl(1, 1);
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(15) == 0) begin
                ctl_en = ($urandom_range(7) != 0);
                ctl_arm = ($urandom_range(3) != 0);
                ctl_wr = 1;
            end
            if ($urandom_range(11) == 0) begin chan = CW'($urandom); chan_wr = 1; end
            if ($urandom_range(5) == 0) trig = ~trig;
            if ($urandom_range(19) == 0) stray = 1;
            if ($urandom_range(31) == 0) ana[$urandom_range(NCH-1)] = DW'($urandom);
            step();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule